// File: doc/BRIEF.md
# Lockable Q-Channel Subcode Capture Register

This block holds one complete Q-channel subcode frame of twelve bytes and lets a processor read it through a small read-only register window. An upstream assembler hands over whole frames, one strobe per frame. While the block is unlocked, each new frame replaces the stored one and raises a ready flag.

The processor first reads the status register. If that read finds the ready flag set, the read also locks the stored frame. From then on, incoming frames are dropped and a sticky missed flag records the loss. The processor then reads as many bytes as it needs from the data register, one byte per read and in order. To finish, it reads a release address that carries no data. That read unlocks the buffer, clears the ready flag and rewinds the byte pointer. Capture then resumes with the next frame.

Every read returns its result on `rd_data` one clock after the read request has been sampled. `rd_data` keeps that value until the next read.

Top module: `subq_capture`

## Requirements
- R1: After reset, the ready, locked and missed flags are clear and `rd_data` is 0x00.
- R2: A frame strobe while unlocked stores the twelve bytes (byte k at `frame_data[8k+7:8k]`) and sets ready. A later frame while still unlocked overwrites the stored frame.
- R3: A read of address 0 (status) returns bit 0 = ready and bit 1 = missed, with all other bits 0. The values are those held before the read. If ready was 1, the read locks the buffer.
- R4: A status read that returns ready = 0 leaves the buffer unlocked, so the next frame is still captured.
- R5: While locked, each read of address 1 (data) returns the next stored byte, starting at byte 0.
- R6: Data reads return 0x00 and do not move the byte pointer in two cases: after all twelve bytes have been read, and while the buffer is unlocked.
- R7: A frame that arrives while the buffer is locked is discarded and sets missed. This includes a frame in the same cycle as the locking status read. Missed is cleared by the next status read, unless a frame is dropped in that same cycle.
- R8: A read of address 2 (release) returns 0x00, unlocks the buffer, clears ready and rewinds the byte pointer to 0. A frame strobed in that same cycle is discarded and sets missed.
- R9: A read of address 3 returns 0x00 and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_valid | input | 1 | One-cycle strobe: a full frame is present on frame_data |
| frame_data | input | 96 | Twelve frame bytes, byte 0 in the low bits |
| rd_en | input | 1 | Read request |
| rd_addr | input | 2 | Read address: 0 status, 1 data, 2 release, 3 unused |
| rd_data | output | 8 | Result of the last read, valid one cycle after the request |

## Verification
Frames are built from an arithmetic byte pattern that differs for each frame number. This means any byte returned from the wrong frame or the wrong position shows up as a mismatch.

A sweep runs capture, lock, partial read of 0 to 12 bytes, and release across many frames. This separates a correct pointer rewind from one that carries over between frames. Two frames pushed back to back before locking tell overwrite apart from keep-first behaviour.

Frames are also strobed in the same cycle as a locking status read and in the same cycle as a release read. These cases separate a design that discards frames at those moments from one that lets them slip through. Over-reads, reads while unlocked and reads of the unused address show whether the pointer and flags stay untouched when they should.

// File: rtl/subq_pkg.sv
package subq_pkg;
  typedef enum logic [1:0] {
    ADDR_STATUS  = 2'd0,
    ADDR_DATA    = 2'd1,
    ADDR_RELEASE = 2'd2,
    ADDR_SPARE   = 2'd3
  } subq_addr_e;

  localparam int unsigned ST_READY_BIT  = 0;
  localparam int unsigned ST_MISSED_BIT = 1;
endpackage

// File: rtl/subq_store.sv
module subq_store #(
  parameter int unsigned NUM_BYTES = 12,
  parameter int unsigned BYTE_W    = 8,
  localparam int unsigned FRAME_W  = NUM_BYTES * BYTE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_valid,
  input  logic [FRAME_W-1:0] frame_data,
  input  logic               status_rd,
  input  logic               release_rd,
  output logic [FRAME_W-1:0] frame_q,
  output logic               ready_q,
  output logic               locked_q,
  output logic               missed_q
);
  logic               lock_now;
  logic               discard;
  logic               capture;
  logic               ready_d;
  logic               locked_d;
  logic               missed_d;
  logic [FRAME_W-1:0] frame_d;

  always_comb begin
    lock_now = locked_q | (status_rd & ready_q);
    discard  = frame_valid & (lock_now | release_rd);
    capture  = frame_valid & ~discard;
    frame_d  = capture ? frame_data : frame_q;
    if (release_rd) begin
      ready_d  = 1'b0;
      locked_d = 1'b0;
    end else begin
      ready_d  = ready_q | capture;
      locked_d = lock_now;
    end
    if (discard)        missed_d = 1'b1;
    else if (status_rd) missed_d = 1'b0;
    else                missed_d = missed_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q  <= 1'b0;
      locked_q <= 1'b0;
      missed_q <= 1'b0;
    end else begin
      ready_q  <= ready_d;
      locked_q <= locked_d;
      missed_q <= missed_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
    end else if (capture) begin
      frame_q <= frame_d;
    end
  end

  a_r7_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> $stable(frame_q));
  a_r4_lock_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_q) |-> $past(ready_q));
  a_r7_missed_on_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && locked_q) |=> missed_q);
  a_r8_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
    release_rd |=> (!locked_q && !ready_q));
  a_r2_capture_sets_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && !locked_q && !status_rd && !release_rd) |=> ready_q);
endmodule

// File: rtl/subq_reader.sv
module subq_reader #(
  parameter int unsigned NUM_BYTES = 12,
  parameter int unsigned BYTE_W    = 8,
  localparam int unsigned FRAME_W  = NUM_BYTES * BYTE_W,
  localparam int unsigned IDX_W    = $clog2(NUM_BYTES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               data_rd,
  input  logic               release_rd,
  input  logic               locked,
  input  logic [FRAME_W-1:0] frame_q,
  output logic [BYTE_W-1:0]  byte_o
);
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] idx_d;
  logic             in_range;

  always_comb begin
    in_range = locked && (idx_q < IDX_W'(NUM_BYTES));
    byte_o   = '0;
    for (int unsigned i = 0; i < NUM_BYTES; i++) begin
      if (in_range && (idx_q == IDX_W'(i))) byte_o = frame_q[i*BYTE_W +: BYTE_W];
    end
    if (release_rd)               idx_d = '0;
    else if (data_rd && in_range) idx_d = idx_q + IDX_W'(1);
    else                          idx_d = idx_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  a_r6_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= IDX_W'(NUM_BYTES));
  a_r5_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && locked && !release_rd && (idx_q < IDX_W'(NUM_BYTES)))
      |=> (idx_q == $past(idx_q) + IDX_W'(1)));
  a_r6_no_move_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && !release_rd) |=> $stable(idx_q));
endmodule

// File: rtl/subq_capture.sv
module subq_capture #(
  parameter int unsigned NUM_BYTES = 12,
  parameter int unsigned BYTE_W    = 8,
  localparam int unsigned FRAME_W  = NUM_BYTES * BYTE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_valid,
  input  logic [FRAME_W-1:0] frame_data,
  input  logic               rd_en,
  input  logic [1:0]         rd_addr,
  output logic [BYTE_W-1:0]  rd_data
);
  import subq_pkg::*;

  logic               status_rd;
  logic               data_rd;
  logic               release_rd;
  logic [FRAME_W-1:0] frame_q;
  logic               ready_q;
  logic               locked_q;
  logic               missed_q;
  logic [BYTE_W-1:0]  byte_sel;
  logic [BYTE_W-1:0]  status_byte;
  logic [BYTE_W-1:0]  rd_data_d;

  always_comb begin
    status_rd  = rd_en && (subq_addr_e'(rd_addr) == ADDR_STATUS);
    data_rd    = rd_en && (subq_addr_e'(rd_addr) == ADDR_DATA);
    release_rd = rd_en && (subq_addr_e'(rd_addr) == ADDR_RELEASE);
    status_byte = '0;
    status_byte[ST_READY_BIT]  = ready_q;
    status_byte[ST_MISSED_BIT] = missed_q;
    case (subq_addr_e'(rd_addr))
      ADDR_STATUS: rd_data_d = status_byte;
      ADDR_DATA:   rd_data_d = byte_sel;
      default:     rd_data_d = '0;
    endcase
  end

  subq_store #(.NUM_BYTES(NUM_BYTES), .BYTE_W(BYTE_W)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_valid(frame_valid),
    .frame_data (frame_data),
    .status_rd  (status_rd),
    .release_rd (release_rd),
    .frame_q    (frame_q),
    .ready_q    (ready_q),
    .locked_q   (locked_q),
    .missed_q   (missed_q)
  );

  subq_reader #(.NUM_BYTES(NUM_BYTES), .BYTE_W(BYTE_W)) u_reader (
    .clk       (clk),
    .rst_n     (rst_n),
    .data_rd   (data_rd),
    .release_rd(release_rd),
    .locked    (locked_q),
    .frame_q   (frame_q),
    .byte_o    (byte_sel)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else if (rd_en) begin
      rd_data <= rd_data_d;
    end
  end

  a_r3_lock_on_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && ready_q) |=> locked_q);
  a_r9_spare_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == 2'd3 && !frame_valid)
      |=> (rd_data == '0 && $stable(locked_q) && $stable(ready_q)));
endmodule

// File: tb/test_subq_capture.sv
module test_subq_capture;
  localparam int unsigned NB = 12;
  localparam int unsigned BW = 8;

  logic            clk;
  logic            rst_n;
  logic            frame_valid;
  logic [NB*BW-1:0] frame_data;
  logic            rd_en;
  logic [1:0]      rd_addr;
  logic [BW-1:0]   rd_data;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  subq_capture #(.NUM_BYTES(NB), .BYTE_W(BW)) i_subq_capture (
    .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .frame_data(frame_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [7:0] pat(int f, int k);
    return 8'((f * 37 + k * 11 + 5) & 255);
  endfunction

  function automatic logic [NB*BW-1:0] mkframe(int f);
    logic [NB*BW-1:0] v;
    for (int k = 0; k < NB; k++) v[k*8 +: 8] = pat(f, k);
    return v;
  endfunction

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic push(int f);
    @(negedge clk);
    frame_valid = 1'b1;
    frame_data  = mkframe(f);
    @(negedge clk);
    frame_valid = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, bit with_frame, int f, output logic [7:0] d);
    @(negedge clk);
    rd_en   = 1'b1;
    rd_addr = a;
    if (with_frame) begin
      frame_valid = 1'b1;
      frame_data  = mkframe(f);
    end
    @(negedge clk);
    rd_en       = 1'b0;
    frame_valid = 1'b0;
    d = rd_data;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    rst_n = 1'b0; frame_valid = 1'b0; frame_data = '0; rd_en = 1'b0; rd_addr = 2'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rd_data after reset", rd_data, 8'h00);
    rd(2'd0, 0, 0, d); chk("R1 status after reset", d, 8'h00);
    rd(2'd1, 0, 0, d); chk("R6 data while unlocked", d, 8'h00);

    // R4: status read with ready=0 does not lock; frames still captured
    push(0);
    push(1);
    rd(2'd0, 0, 0, d); chk("R4 ready after capture", d, 8'h01);
    for (int k = 0; k < NB; k++) begin
      rd(2'd1, 0, 0, d); chk("R2 R5 byte of newest frame", d, pat(1, k));
    end
    for (int k = 0; k < 2; k++) begin
      rd(2'd1, 0, 0, d); chk("R6 over-read", d, 8'h00);
    end
    push(2);
    rd(2'd0, 0, 0, d); chk("R7 missed set while locked", d, 8'h03);
    rd(2'd0, 0, 0, d); chk("R7 missed cleared by status read", d, 8'h01);
    rd(2'd2, 0, 0, d); chk("R8 release returns zero", d, 8'h00);
    rd(2'd0, 0, 0, d); chk("R8 ready clear after release", d, 8'h00);
    rd(2'd1, 0, 0, d); chk("R6 data after release", d, 8'h00);

    // sweep: partial reads, then release, pointer rewinds each time
    for (int f = 3; f < 30; f++) begin
      int n;
      n = (f * 5) % 13;
      push(f);
      rd(2'd0, 0, 0, d); chk("R3 status locks", d, 8'h01);
      for (int k = 0; k < n; k++) begin
        rd(2'd1, 0, 0, d); chk("R5 sweep byte", d, pat(f, k));
      end
      rd(2'd2, 0, 0, d); chk("R8 sweep release", d, 8'h00);
      rd(2'd0, 0, 0, d); chk("R8 sweep status", d, 8'h00);
    end

    // R9: spare address is inert
    push(40);
    rd(2'd3, 0, 0, d); chk("R9 spare unlocked", d, 8'h00);
    rd(2'd0, 0, 0, d); chk("R9 status unaffected", d, 8'h01);
    rd(2'd3, 0, 0, d); chk("R9 spare locked", d, 8'h00);
    rd(2'd1, 0, 0, d); chk("R9 pointer unaffected", d, pat(40, 0));
    rd(2'd2, 0, 0, d); chk("R8 release", d, 8'h00);

    // R7: frame in the same cycle as the locking status read is dropped
    push(41);
    rd(2'd0, 1, 42, d); chk("R7 status pre-values", d, 8'h01);
    for (int k = 0; k < NB; k++) begin
      rd(2'd1, 0, 0, d); chk("R7 kept frame byte", d, pat(41, k));
    end
    rd(2'd0, 1, 43, d); chk("R7 missed seen", d, 8'h03);
    rd(2'd0, 0, 0, d); chk("R7 set wins over clear", d, 8'h03);
    rd(2'd0, 0, 0, d); chk("R7 missed cleared", d, 8'h01);

    // R8: frame in the release cycle is dropped
    rd(2'd2, 1, 44, d); chk("R8 release with frame", d, 8'h00);
    rd(2'd0, 0, 0, d); chk("R8 frame dropped at release", d, 8'h02);
    rd(2'd0, 0, 0, d); chk("R8 idle after release", d, 8'h00);
    rd(2'd1, 0, 0, d); chk("R6 unlocked data", d, 8'h00);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule